// File: doc/BRIEF.md
# Prescaled 16-bit Reload Down-Timer

This block is a 16-bit down-counter clocked by a divided copy of the system clock. Software reaches it through a small synchronous register port. The port gives access to a control/status register, a reload value and a read-only view of the live count. A two-bit select field sets the division ratio. A software trigger loads the reload value and starts counting.

On each prescaled tick the count drops by one. When the count steps from 0000h to FFFFh, the block records an underflow. In continuous mode it then reloads and keeps going. In one-shot mode it stops, and the count stays at FFFFh. Every underflow sets a sticky flag, and that flag can drive an interrupt request.

The configuration fields are frozen while counting is enabled. Only the flag, enable and trigger bits can be written at any time. Several control fields are stored but have no effect on behaviour.

Top module: `reload_timer16`

## Requirements
- R1: After reset, the control word, reload register and count all read 0000h, and `irq` is 0.
- R2: The port decodes three addresses, and `rdata` follows `addr` combinationally.
  - Address 0 is control, address 1 is reload (read/write) and address 2 is the count (read-only; writes to it change nothing).
  - Control bit fields are: 11:10 divider select, 9:7 mode, 6 output enable, 5 output level, 4 reload enable, 3 interrupt enable, 2 underflow flag, 1 count enable, 0 trigger.
  - Bits 15:12 and bit 0 always read 0.
- R3: Divider select codes 00, 01 and 10 decrement the count once every 2, 8 and 32 clocks. The first decrement lands exactly that many clock edges after the edge that takes the trigger write.
- R4: Divider select code 11 produces no ticks, so the count stays at its loaded value.
- R5: A control write with bit 1 = 1 and bit 0 = 1 loads the reload value into the count and restarts the divider. This also applies when the count is already running.
- R6: When the count is 0000h, the next tick is an underflow. With reload enable = 1, the underflow loads the reload value and counting continues.
- R7: With reload enable = 0, an underflow leaves the count at FFFFh and counting stops.
- R8: Every underflow sets the flag at bit 2. Writing 0 to bit 2 clears it, and writing 1 to bit 2 leaves it unchanged.
- R9: `irq` is 1 exactly when the underflow flag and interrupt enable are both 1.
- R10: A control write issued while count enable is 1 leaves bits 11:3 unchanged. The flag, enable and trigger bits of that same write still take effect.
- R11: The mode, output-enable and output-level bits are stored and read back, and they do not change counting.
- R12: Writing count enable = 0 stops decrementing, and the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches several behaviours on every cycle:
- that each tick decrements the count by one;
- that the count reloads or parks at FFFFh on underflow;
- that the flag is set by an underflow and rises only after one;
- that the interrupt output is consistent with the flag and the enable;
- that the divider stays silent under the reserved code;
- that the configuration fields are frozen while counting.

Other properties can only be shown by the bench's scenarios. These include the exact tick spacing for each divider, the count value after many reload periods, and the readback of stored-but-inert bits. They also include the ignored write to the count address, a clear of the flag by software, and the count holding its value after counting is disabled.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned CFG_W  = 9;

  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] A_COUNT  = 2'd2;

  localparam int unsigned B_FLAG = 2;
  localparam int unsigned B_EN   = 1;
  localparam int unsigned B_TRG  = 0;
  localparam int unsigned CFG_LO = 3;

  // log2 of each divider ratio, indexed by select code
  localparam int unsigned N_DIV = 3;
  localparam int unsigned DIV_LOG2 [0:N_DIV-1] = '{1, 3, 5};
  localparam int unsigned PRE_W = 5;

  typedef enum logic [1:0] {
    SEL_DIV2  = 2'd0,
    SEL_DIV8  = 2'd1,
    SEL_DIV32 = 2'd2,
    SEL_HALT  = 2'd3
  } div_sel_e;

  typedef struct packed {
    div_sel_e   sel;
    logic [2:0] mode;
    logic       out_en;
    logic       out_lvl;
    logic       reload_en;
    logic       irq_en;
  } cfg_t;
endpackage

// File: rtl/rtm_rst_sync.sv
module rtm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rtm_prescale.sv
module rtm_prescale
  import rtm_pkg::*;
#(
  parameter int unsigned PW = PRE_W
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     restart,
  input  div_sel_e sel,
  output logic     tick
);
  logic [PW-1:0] div_q, div_d;
  logic [3:0]    taps;

  always_comb begin
    div_d = div_q + 1'b1;
    if (restart || !run) div_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  for (genvar g = 0; g < N_DIV; g++) begin : g_tap
    assign taps[g] = &div_q[DIV_LOG2[g]-1:0];
  end
  assign taps[3] = 1'b0;

  assign tick = run & taps[sel];
endmodule

// File: rtl/rtm_ctrl_reg.sv
module rtm_ctrl_reg
  import rtm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              uf_set,
  output cfg_t              cfg,
  output logic              flag,
  output logic              cnt_en,
  output logic              trig
);
  cfg_t cfg_q, cfg_d;
  logic flag_q, flag_d;
  logic en_q, en_d;
  logic cfg_we;

  assign cfg_we = wr_ctrl & ~en_q;

  always_comb begin
    cfg_d  = cfg_q;
    en_d   = en_q;
    flag_d = flag_q;
    if (cfg_we)  cfg_d = cfg_t'(wdata[CFG_LO +: CFG_W]);
    if (wr_ctrl) en_d = wdata[B_EN];
    if (wr_ctrl && !wdata[B_FLAG]) flag_d = 1'b0;
    if (uf_set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      en_q   <= en_d;
      flag_q <= flag_d;
    end
  end

  assign trig   = wr_ctrl & wdata[B_TRG] & wdata[B_EN];
  assign cfg    = cfg_q;
  assign flag   = flag_q;
  assign cnt_en = en_q;
endmodule

// File: rtl/rtm_counter.sv
module rtm_counter
  import rtm_pkg::*;
#(
  parameter int unsigned CW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          trig,
  input  logic          cnt_en,
  input  logic          reload_en,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] count,
  output logic          running,
  output logic          uf_event
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          cnt_ce;

  always_comb begin
    cnt_d    = cnt_q;
    run_d    = run_q;
    uf_event = 1'b0;
    if (trig) begin
      cnt_d = reload;
      run_d = 1'b1;
    end else if (!cnt_en) begin
      run_d = 1'b0;
    end else if (run_q && tick) begin
      if (cnt_q == '0) begin
        uf_event = 1'b1;
        if (reload_en) begin
          cnt_d = reload;
        end else begin
          cnt_d = '1;
          run_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  assign cnt_ce = trig | (cnt_en & run_q & tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
      if (cnt_ce) cnt_q <= cnt_d;
    end
  end

  assign count   = cnt_q;
  assign running = run_q;
endmodule

// File: rtl/reload_timer16.sv
module reload_timer16
  import rtm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic              rst_sync_n;
  cfg_t              cfg;
  logic              flag, cnt_en, trig, tick, running, uf_event;
  logic [DATA_W-1:0] reload_q, reload_d, count;
  logic [CFG_W-1:0]  cfg_bits;
  logic              reload_en, irq_en;
  logic [1:0]        sel_bits;
  logic              wr_ctrl, wr_reload;

  assign wr_ctrl   = wr_en & (addr == A_CTRL);
  assign wr_reload = wr_en & (addr == A_RELOAD);

  rtm_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  rtm_ctrl_reg i_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .wr_ctrl(wr_ctrl), .wdata(wdata),
    .uf_set(uf_event), .cfg(cfg), .flag(flag), .cnt_en(cnt_en), .trig(trig)
  );

  rtm_prescale #(.PW(PRE_W)) i_pre (
    .clk(clk), .rst_n(rst_sync_n), .run(running), .restart(trig),
    .sel(cfg.sel), .tick(tick)
  );

  rtm_counter #(.CW(DATA_W)) i_cnt (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .trig(trig),
    .cnt_en(cnt_en), .reload_en(cfg.reload_en), .reload(reload_q),
    .count(count), .running(running), .uf_event(uf_event)
  );

  always_comb begin
    reload_d = reload_q;
    if (wr_reload) reload_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) reload_q <= '0;
    else             reload_q <= reload_d;
  end

  assign cfg_bits  = cfg;
  assign reload_en = cfg.reload_en;
  assign irq_en    = cfg.irq_en;
  assign sel_bits  = cfg.sel;

  always_comb begin
    unique case (addr)
      A_CTRL:   rdata = {{(DATA_W-CFG_LO-CFG_W){1'b0}}, cfg_bits, flag, cnt_en, 1'b0};
      A_RELOAD: rdata = reload_q;
      A_COUNT:  rdata = count;
      default:  rdata = '0;
    endcase
  end

  assign irq = flag & cfg.irq_en;
endmodule

// File: rtl/rtm_checker.sv
module rtm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cnt_en,
  input logic [8:0]  cfg_bits,
  input logic [15:0] count,
  input logic [15:0] reload,
  input logic        running,
  input logic        tick,
  input logic        trig,
  input logic        flag,
  input logic        irq_en,
  input logic        reload_en,
  input logic        uf_event,
  input logic        irq,
  input logic [1:0]  sel,
  input logic [1:0]  addr,
  input logic [15:0] rdata
);
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt_en && tick && !trig && count != 16'h0) |=> count == $past(count) - 16'd1);

  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_event && reload_en) |=> (count == $past(reload) && running));

  a_r7_park: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_event && !reload_en) |=> (count == 16'hFFFF && !running));

  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    uf_event |=> flag);

  a_r8_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(uf_event));

  a_r9_irq_en: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && flag));

  a_r9_irq_req: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && irq_en) |-> irq);

  a_r4_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11) |-> !tick);

  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_en) |-> $stable(cfg_bits));

  a_r2_trg_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd0) |-> !rdata[0]);
endmodule

bind reload_timer16 rtm_checker i_rtm_checker (
  .clk(clk), .rst_n(rst_sync_n), .cnt_en(cnt_en), .cfg_bits(cfg_bits),
  .count(count), .reload(reload_q), .running(running), .tick(tick),
  .trig(trig), .flag(flag), .irq_en(irq_en), .reload_en(reload_en),
  .uf_event(uf_event), .irq(irq), .sel(sel_bits), .addr(addr), .rdata(rdata)
);

// File: tb/test_reload_timer16.sv
module test_reload_timer16;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reload_timer16 i_reload_timer16 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  typedef struct packed {
    logic [15:0] rl;
    logic [1:0]  sel;
    logic        rld;
    logic [15:0] wait_n;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [0:NV-1] = '{
    '{16'd5,   2'b00, 1'b1, 16'd20},
    '{16'd5,   2'b00, 1'b0, 16'd20},
    '{16'd3,   2'b01, 1'b1, 16'd40},
    '{16'd100, 2'b10, 1'b0, 16'd320},
    '{16'd0,   2'b00, 1'b1, 16'd7},
    '{16'd2,   2'b11, 1'b1, 16'd50},
    '{16'd7,   2'b01, 1'b0, 16'd64}
  };

  function automatic int ticks_of(logic [1:0] sel, int k);
    case (sel)
      2'b00:   return k / 2;
      2'b01:   return k / 8;
      2'b10:   return k / 32;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] exp_count(int rl, logic rld, int t);
    if (rld)      return 16'(rl - (t % (rl + 1)));
    else if (t <= rl) return 16'(rl - t);
    else          return 16'hFFFF;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic wait_edges(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  // control word: sel[11:10] mode[9:7] oe[6] ol[5] rld[4] ie[3] flag[2] en[1] trg[0]
  function automatic logic [15:0] ctl(logic [1:0] sel, logic rld, logic ie,
                                      logic flg, logic en, logic trg);
    return {4'b0, sel, 3'b000, 1'b0, 1'b0, rld, ie, flg, en, trg};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int t;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    wait_edges(4);

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 16'h0);
    rd(2'd1, v); check("R1 reload", v, 16'h0);
    rd(2'd2, v); check("R1 count", v, 16'h0);
    check("R1 irq", {15'b0, irq}, 16'h0);

    // R2 count address is read-only
    wr(2'd2, 16'h1234);
    rd(2'd2, v); check("R2 count write ignored", v, 16'h0);
    wr(2'd1, 16'hBEEF);
    rd(2'd1, v); check("R2 reload rw", v, 16'hBEEF);

    // table walk: R3 R4 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, 16'h0);
      wr(2'd1, VECS[i].rl);
      wr(2'd0, ctl(VECS[i].sel, VECS[i].rld, 1'b0, 1'b0, 1'b1, 1'b1));
      wait_edges(int'(VECS[i].wait_n));
      t = ticks_of(VECS[i].sel, int'(VECS[i].wait_n));
      rd(2'd2, v);
      check($sformatf("R3/R4/R6/R7 vec%0d count", i), v,
            exp_count(int'(VECS[i].rl), VECS[i].rld, t));
      rd(2'd0, v);
      check($sformatf("R8 vec%0d ctrl readback", i), v,
            ctl(VECS[i].sel, VECS[i].rld, 1'b0, t > int'(VECS[i].rl), 1'b1, 1'b0));
      check($sformatf("R9 vec%0d irq masked", i), {15'b0, irq}, 16'h0);
    end

    // R3 exact first-tick boundary, divide by 8
    wr(2'd0, 16'h0);
    wr(2'd1, 16'd10);
    wr(2'd0, ctl(2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    wait_edges(7);
    rd(2'd2, v); check("R3 before first tick", v, 16'd10);
    wait_edges(1);
    rd(2'd2, v); check("R3 at first tick", v, 16'd9);

    // R10 config write while counting ignored
    wr(2'd0, 16'h0);
    wr(2'd1, 16'd50);
    wr(2'd0, ctl(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    wait_edges(10);
    wr(2'd0, ctl(2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0));
    rd(2'd0, v); check("R10 cfg frozen", v, 16'h0002);
    rd(2'd2, v); check("R10 counting unaffected", v, 16'd45);

    // R5 retrigger mid-count
    wr(2'd0, 16'h0);
    wr(2'd1, 16'd100);
    wr(2'd0, ctl(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    wait_edges(20);
    rd(2'd2, v); check("R5 mid count", v, 16'd90);
    wr(2'd0, ctl(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    wait_edges(4);
    rd(2'd2, v); check("R5 retriggered", v, 16'd98);

    // R12 disable holds count (edge 21 after trigger is not a tick edge)
    wr(2'd0, 16'h0);
    wr(2'd0, ctl(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    wait_edges(20);
    wr(2'd0, ctl(2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
    wait_edges(10);
    rd(2'd2, v); check("R12 count held", v, 16'd90);

    // R8 / R9 flag stickiness and interrupt
    wr(2'd0, 16'h0);
    wr(2'd1, 16'd1);
    wr(2'd0, ctl(2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1));
    wait_edges(10);
    check("R9 irq raised", {15'b0, irq}, 16'h1);
    wr(2'd0, ctl(2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0));
    rd(2'd0, v); check("R8 write 1 keeps flag", v[2] ? 16'h1 : 16'h0, 16'h1);
    wr(2'd0, ctl(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    rd(2'd0, v); check("R8 write 0 clears flag", v, 16'h0018 & 16'h0008);
    check("R9 irq dropped", {15'b0, irq}, 16'h0);

    // R11 inert mode/output bits
    wr(2'd1, 16'd4);
    wr(2'd0, 16'h03F3);
    wait_edges(10);
    rd(2'd2, v); check("R11 count with inert bits", v, 16'd4);
    rd(2'd0, v); check("R11 readback", v, 16'h03F6);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule